// File: doc/BRIEF.md
# Output Voltage Setting Receiver (Two-Wire Bus)

This block is a write-only target on a two-wire serial bus. It holds the level code that sets a DC/DC converter's output voltage. A fast system clock samples SCL and SDA. Each line passes through a two-flop synchronizer and then a three-sample agreement filter. The filtered lines drive edge detection, START/STOP detection and a byte receiver. The block never sends data: SCL is only an input, and the block pulls SDA low only to acknowledge a byte.

A transaction has three parts:

- The controller sends START and then the address byte 0x10, which is 7-bit address 0x08 with the write bit at 0.
- It then sends a word address.
- It then sends one or more data bytes.

The word address steps up by one after each data byte. Only word address 00h holds a register. Bytes sent to any other word address are acknowledged and have no effect. The outputs are the 6-bit level code, the target voltage in 0.1 V units (15 plus the code, so 1.5 V to 5.5 V), and a flag that rises on the first accepted write.

The receiver state machine has seven states:

- ST_IDLE: not addressed.
- ST_ADDR, ST_WADR, ST_DATA: receiving the address byte, the word address and the data bytes.
- ST_ADDR_ACK, ST_WADR_ACK, ST_DATA_ACK: the acknowledge slot that follows each byte.

Its transitions are:

- START moves any state to ST_ADDR.
- STOP moves any state to ST_IDLE.
- In ST_ADDR, the SCL fall that ends the eighth bit goes to ST_ADDR_ACK when the byte matches and to ST_IDLE when it does not.
- The SCL fall that ends the eighth bit moves ST_WADR to ST_WADR_ACK and ST_DATA to ST_DATA_ACK.
- At the SCL fall that ends the acknowledge slot, ST_ADDR_ACK goes to ST_WADR, ST_WADR_ACK goes to ST_DATA, and ST_DATA_ACK goes back to ST_DATA.

Top module: `vout_i2c_slave`

## Requirements
- R1: Only the first byte after START equal to 0x10 is acknowledged. For any other first byte the block leaves SDA released for the rest of the transaction, until the next START.
- R2: The block pulls SDA low only during the acknowledge slot that follows the eighth bit of a byte. The pull starts and ends while SCL is low, and the block never sends any other bits.
- R3: The second byte is the word address. The level register is at word address 00h.
- R4: A data byte is read as bits 7:6 reserved and bits 5:0 the level code. Codes 0 to 40 written at word address 00h are stored and appear on level_o.
- R5: A data byte with a code above 40, or with bit 7 or bit 6 set, is acknowledged and leaves level_o unchanged.
- R6: The word address increases by one after each data byte. Further data bytes in the same transaction are acknowledged and have no effect, and so do bytes written to any nonzero word address.
- R7: target_dv_o is always 15 plus level_o, in units of 0.1 V.
- R8: After reset, level_o is 0 and programmed_o is 0. programmed_o goes high on the first accepted write and stays high until reset.
- R9: A repeated START in any state, including in the middle of a byte, drops the byte in progress and restarts address matching.
- R10: A pulse of up to two system-clock samples on SCL or on SDA is filtered out, so it causes no extra bit and no START or STOP.
- R11: Transfers work at 400 kbit/s with the default 250 MHz sampling clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_pull_o | output | 1 | 1 drives SDA low (open-drain acknowledge) |
| level_o | output | 6 | Stored level code, 0 to 40 |
| target_dv_o | output | 7 | Target voltage in 0.1 V units (15..55) |
| programmed_o | output | 1 | High once a valid level has been written |

## Verification
The assertions check on every cycle that:

- the stored code never rises above 40;
- the programmed flag never falls once set;
- the code never changes while the flag is low;
- the acknowledge pull on SDA starts and ends only while the filtered SCL is low.

Other behaviour can only be shown by the bench's scenarios: address matching, rejection of out-of-range codes, the word-address increment, abort on a repeated START, and glitch rejection. To show these, the bench sweeps all 64 values of the low six bits, writes bytes with the reserved bits set, sends wrong addresses, restarts in the middle of a byte and injects short pulses on each line.

// File: rtl/vreg_pkg.sv
package vreg_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WADR,
        ST_WADR_ACK,
        ST_DATA,
        ST_DATA_ACK
    } rx_state_t;

endpackage

// File: rtl/bus_filter.sv
module bus_filter #(
    parameter int LANES       = 2,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] raw_i,
    output logic [LANES-1:0] filt_o
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [SYNC_STAGES-1:0] sync_q;
        logic [FILT_LEN-1:0]    hist_q;
        logic                   level_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sync_q  <= '1;
                hist_q  <= '1;
                level_q <= 1'b1;
            end else begin
                sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i[g]};
                hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
                // the filtered level moves only when every held sample agrees
                if (&hist_q) begin
                    level_q <= 1'b1;
                end else if (~|hist_q) begin
                    level_q <= 1'b0;
                end
            end
        end

        assign filt_o[g] = level_q;
    end

endmodule

// File: rtl/i2c_rx_fsm.sv
module i2c_rx_fsm
    import vreg_pkg::*;
#(
    parameter logic [6:0] SLV_ADDR = 7'h08
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_f,
    input  logic              sda_f,
    output logic              ack_pull,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_data
);

    localparam logic [BYTE_W-1:0] ADDR_BYTE = {SLV_ADDR, 1'b0};
    localparam int                CNT_W     = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0]  LAST_BIT  = CNT_W'(BYTE_W);

    rx_state_t          state, nxt;
    logic               scl_q, sda_q;
    logic [BYTE_W-1:0]  shreg;
    logic [BYTE_W-1:0]  waddr;
    logic [CNT_W-1:0]   bit_cnt;
    logic               scl_rise, scl_fall, bus_start, bus_stop;
    logic               byte_done, in_rx, in_ack;

    assign scl_rise  = scl_f & ~scl_q;
    assign scl_fall  = ~scl_f & scl_q;
    assign bus_start = scl_f & scl_q & sda_q & ~sda_f;
    assign bus_stop  = scl_f & scl_q & ~sda_q & sda_f;
    assign byte_done = scl_fall && (bit_cnt == LAST_BIT);
    assign in_rx     = (state == ST_ADDR) || (state == ST_WADR) || (state == ST_DATA);
    assign in_ack    = (state == ST_ADDR_ACK) || (state == ST_WADR_ACK) || (state == ST_DATA_ACK);

    // next-state logic
    always_comb begin
        nxt = state;
        if (bus_start) begin
            nxt = ST_ADDR;
        end else if (bus_stop) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_ADDR:     if (byte_done) nxt = (shreg == ADDR_BYTE) ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK: if (scl_fall) nxt = ST_WADR;
                ST_WADR:     if (byte_done) nxt = ST_WADR_ACK;
                ST_WADR_ACK: if (scl_fall) nxt = ST_DATA;
                ST_DATA:     if (byte_done) nxt = ST_DATA_ACK;
                ST_DATA_ACK: if (scl_fall) nxt = ST_DATA;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // state register and receive datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            scl_q   <= 1'b1;
            sda_q   <= 1'b1;
            shreg   <= '0;
            waddr   <= '0;
            bit_cnt <= '0;
        end else begin
            state <= nxt;
            scl_q <= scl_f;
            sda_q <= sda_f;
            if (bus_start || (in_ack && scl_fall)) begin
                bit_cnt <= '0;
            end else if (in_rx && scl_rise) begin
                bit_cnt <= bit_cnt + 1'b1;
                shreg   <= {shreg[BYTE_W-2:0], sda_f};
            end
            if (state == ST_WADR && byte_done) begin
                waddr <= shreg;
            end else if (state == ST_DATA && byte_done) begin
                waddr <= waddr + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        ack_pull = in_ack;
        wr_en    = (state == ST_DATA) && byte_done && (waddr == '0);
        wr_data  = shreg;
    end

endmodule

// File: rtl/vlevel_reg.sv
module vlevel_reg
    import vreg_pkg::*;
#(
    parameter int LVL_W   = 6,
    parameter int LVL_MAX = 40,
    parameter int BASE_DV = 15,
    parameter int DV_W    = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [LVL_W-1:0]  level,
    output logic [DV_W-1:0]   target_dv,
    output logic              programmed
);

    localparam int               UP_W = BYTE_W - LVL_W;
    localparam logic [LVL_W-1:0] MAXC = LVL_W'(LVL_MAX);

    logic accept;

    assign accept = wr_en
                  && (wr_data[BYTE_W-1 -: UP_W] == '0)
                  && (wr_data[LVL_W-1:0] <= MAXC);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level      <= '0;
            programmed <= 1'b0;
        end else if (accept) begin
            level      <= wr_data[LVL_W-1:0];
            programmed <= 1'b1;
        end
    end

    assign target_dv = DV_W'(BASE_DV) + DV_W'(level);

endmodule

// File: rtl/vout_i2c_slave.sv
module vout_i2c_slave
    import vreg_pkg::*;
#(
    parameter logic [6:0] SLV_ADDR    = 7'h08,
    parameter int         LVL_W       = 6,
    parameter int         LVL_MAX     = 40,
    parameter int         BASE_DV     = 15,
    parameter int         DV_W        = 7,
    parameter int         SYNC_STAGES = 2,
    parameter int         FILT_LEN    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_pull_o,
    output logic [LVL_W-1:0] level_o,
    output logic [DV_W-1:0]  target_dv_o,
    output logic             programmed_o
);

    logic [1:0]        filt;
    logic              scl_f, sda_f;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_data;

    bus_filter #(
        .LANES      (2),
        .SYNC_STAGES(SYNC_STAGES),
        .FILT_LEN   (FILT_LEN)
    ) u_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i ({sda_i, scl_i}),
        .filt_o(filt)
    );

    assign scl_f = filt[0];
    assign sda_f = filt[1];

    i2c_rx_fsm #(
        .SLV_ADDR(SLV_ADDR)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_f   (scl_f),
        .sda_f   (sda_f),
        .ack_pull(sda_pull_o),
        .wr_en   (wr_en),
        .wr_data (wr_data)
    );

    vlevel_reg #(
        .LVL_W  (LVL_W),
        .LVL_MAX(LVL_MAX),
        .BASE_DV(BASE_DV),
        .DV_W   (DV_W)
    ) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .level     (level_o),
        .target_dv (target_dv_o),
        .programmed(programmed_o)
    );

endmodule

// File: rtl/vout_i2c_chk.sv
module vout_i2c_chk #(
    parameter int LVL_W   = 6,
    parameter int LVL_MAX = 40
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_f,
    input logic             sda_pull_o,
    input logic [LVL_W-1:0] level_o,
    input logic             programmed_o
);

    // R4
    level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(level_o) <= LVL_MAX);

    // R8
    prog_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        programmed_o |=> programmed_o);

    // R8
    level_moves_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(level_o) |-> programmed_o);

    // R2
    ack_start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> !scl_f);

    // R2
    ack_end_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_pull_o) |-> !scl_f);

endmodule

bind vout_i2c_slave vout_i2c_chk #(
    .LVL_W  (LVL_W),
    .LVL_MAX(LVL_MAX)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_f       (scl_f),
    .sda_pull_o  (sda_pull_o),
    .level_o     (level_o),
    .programmed_o(programmed_o)
);

// File: tb/sim_vout_i2c_slave.sv
module sim_vout_i2c_slave;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_pull;
    logic [5:0] level;
    logic [6:0] target;
    logic       prog;

    int tests = 0;
    int fails = 0;
    int q = 10;
    int exp_lvl = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;

    vout_i2c_slave u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .sda_pull_o  (sda_pull),
        .level_o     (level),
        .target_dv_o (target),
        .programmed_o(prog)
    );

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(q);
        scl_m = 1'b1; wq(q);
        sda_m = 1'b0; wq(q);
        scl_m = 1'b0; wq(q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(q);
        scl_m = 1'b1; wq(q);
        sda_m = 1'b1; wq(4 * q);
    endtask

    // gl_bit: bit index that receives a 2-sample pulse (-1 none); gl_sda picks the line
    task automatic send_byte(input logic [7:0] b, input int gl_bit, input bit gl_sda,
                             output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(q);
            scl_m = 1'b1; wq(q);
            if (i == gl_bit) begin
                if (gl_sda) sda_m = 1'b0; else scl_m = 1'b0;
                wq(2);
                sda_m = b[i];
                scl_m = 1'b1;
            end
            wq(q);
            scl_m = 1'b0; wq(q);
        end
        sda_m = 1'b1; wq(q);
        scl_m = 1'b1; wq(q);
        acked = !sda_line;
        wq(q);
        scl_m = 1'b0; wq(q);
    endtask

    task automatic send_bits4(input logic [3:0] b);
        for (int i = 3; i >= 0; i--) begin
            sda_m = b[i]; wq(q);
            scl_m = 1'b1; wq(2 * q);
            scl_m = 1'b0; wq(q);
        end
    endtask

    // full write to word address 00h; returns 1 when all three bytes were acknowledged
    task automatic write_level(input logic [7:0] d, input int gl_bit, input bit gl_sda,
                               output bit all_ack);
        bit a0, a1, a2;
        bus_start();
        send_byte(8'h10, -1, 1'b0, a0);
        send_byte(8'h00, -1, 1'b0, a1);
        send_byte(d, gl_bit, gl_sda, a2);
        bus_stop();
        all_ack = a0 & a1 & a2;
    endtask

    task automatic check_out(input string req);
        chk({req, " level"}, int'(level), exp_lvl);
        chk("R7 target", int'(target), 15 + exp_lvl);
    endtask

    initial begin
        bit ack, a0, a1, a2, a3;
        wq(5);
        // R8 reset state
        chk("R8 reset level", int'(level), 0);
        chk("R7 reset target", int'(target), 15);
        chk("R8 reset programmed", int'(prog), 0);
        chk("R2 reset sda idle", int'(sda_pull), 0);
        rst_n = 1'b1;
        wq(10);

        // R5 reserved bits set: acknowledged, no effect, flag stays low
        write_level(8'hC5, -1, 1'b0, ack);
        chk("R5 ack reserved", int'(ack), 1);
        check_out("R5");
        chk("R8 not programmed", int'(prog), 0);

        // R4 R5 R7 R8 sweep of every 6-bit value
        for (int c = 0; c < 64; c++) begin
            write_level(8'(c), -1, 1'b0, ack);
            if (c <= 40) exp_lvl = c;
            chk("R4 R5 ack", int'(ack), 1);
            check_out(c <= 40 ? "R4" : "R5");
            chk("R8 programmed", int'(prog), 1);
        end
        write_level(8'h45, -1, 1'b0, ack);
        chk("R5 bit6 ack", int'(ack), 1);
        check_out("R5 bit6");

        // R6 R3 auto-increment: second byte lands on word address 01h
        bus_start();
        send_byte(8'h10, -1, 1'b0, a0);
        send_byte(8'h00, -1, 1'b0, a1);
        send_byte(8'h0C, -1, 1'b0, a2);
        send_byte(8'h21, -1, 1'b0, a3);
        bus_stop();
        exp_lvl = 12;
        chk("R6 acks", int'(a0 & a1 & a2 & a3), 1);
        check_out("R6");
        bus_start();
        send_byte(8'h10, -1, 1'b0, a0);
        send_byte(8'h01, -1, 1'b0, a1);
        send_byte(8'h03, -1, 1'b0, a2);
        bus_stop();
        chk("R3 wadr01 acks", int'(a0 & a1 & a2), 1);
        check_out("R3");

        // R1 wrong address and read bit
        bus_start();
        send_byte(8'h12, -1, 1'b0, a0);
        send_byte(8'h00, -1, 1'b0, a1);
        send_byte(8'h05, -1, 1'b0, a2);
        bus_stop();
        chk("R1 nack addr", int'(a0 | a1 | a2), 0);
        check_out("R1");
        bus_start();
        send_byte(8'h11, -1, 1'b0, a0);
        bus_stop();
        chk("R1 nack read bit", int'(a0), 0);

        // R9 restart mid-byte and restart to a foreign address
        bus_start();
        send_byte(8'h10, -1, 1'b0, a0);
        send_byte(8'h00, -1, 1'b0, a1);
        send_bits4(4'b0010);
        write_level(8'h0A, -1, 1'b0, ack);
        exp_lvl = 10;
        chk("R9 ack after restart", int'(ack), 1);
        check_out("R9");
        bus_start();
        send_byte(8'h10, -1, 1'b0, a0);
        send_byte(8'h00, -1, 1'b0, a1);
        bus_start();
        send_byte(8'h20, -1, 1'b0, a2);
        send_byte(8'h03, -1, 1'b0, a3);
        bus_stop();
        chk("R9 foreign nack", int'(a2 | a3), 0);
        check_out("R9 foreign");

        // R10 glitches: SCL low pulse, SDA low pulse on a 1 bit
        write_level(8'h15, 2, 1'b0, ack);
        exp_lvl = 21;
        chk("R10 scl glitch ack", int'(ack), 1);
        check_out("R10 scl");
        write_level(8'h24, 2, 1'b1, ack);
        exp_lvl = 36;
        chk("R10 sda glitch ack", int'(ack), 1);
        check_out("R10 sda");

        // R11 400 kbit/s: 625 clocks per bit
        q = 156;
        write_level(8'h1F, -1, 1'b0, ack);
        exp_lvl = 31;
        chk("R11 ack", int'(ack), 1);
        check_out("R11");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule